// File: doc/BRIEF.md
# Staggered Half-Width Pipelined Adder

This block adds two 32-bit operands in two 16-bit halves, one fast cycle per half. The lower half is summed in the cycle an operation is accepted. Its carry out is registered and travels, together with the registered upper operand halves, into a second cycle where the upper half is summed. A third cycle registers the carry, zero, sign and overflow flags of the complete result. A new operation can be accepted every cycle, and each accepted operation raises a lower, an upper and a flag valid strobe in three successive cycles.

Because the upper half is not needed until one cycle after the lower half, a dependent addition can start in the cycle right after its producer. Two bypass selects, one per operand, replace that operand with the result of the most recently accepted operation. The lower half of the operand comes from the registered lower result at accept time. The upper half comes from the registered upper result one cycle later, which is exactly when that result has just been produced.

Top module: `stagAdder`

## Requirements
- R1: One cycle after an accepted operation (`inValid` high at a rising edge), `loValid` is high and `loSum` equals bits 15:0 of the operand sum.
- R2: One cycle after `loValid`, `hiValid` is high and `hiSum` equals bits 31:16 of the 32-bit sum, including the carry out of the lower half.
- R3: One cycle after `hiValid`, `flagValid` is high, `flagC` is the carry out of bit 31 and `flagV` is the two's-complement signed overflow of the 32-bit add.
- R4: With `flagValid`, `flagZ` is 1 only when both 16-bit halves of the result are zero, and `flagN` equals bit 31 of the result.
- R5: An operation is accepted on every rising edge where `inValid` is high, including back-to-back edges, and the three valid strobes each follow their predecessor by exactly one cycle.
- R6: When `bypA` is high with an accepted operation, operand A is replaced in full by the 32-bit result of the most recently accepted operation, even when idle cycles separate the two.
- R7: `bypB` does the same for operand B, independently of `bypA`; with both high, the previous result is added to itself.
- R8: While `rstN` is low, all valid strobes, both sums and all flags are zero.
- R9: `loSum` does not change after an edge without an accepted operation, and `hiSum` does not change after an edge where `loValid` was low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Accept the operands on this edge |
| opA | input | 32 | Operand A |
| opB | input | 32 | Operand B |
| bypA | input | 1 | Replace operand A with the previous result |
| bypB | input | 1 | Replace operand B with the previous result |
| loSum | output | 16 | Lower half of the result |
| hiSum | output | 16 | Upper half of the result |
| loValid | output | 1 | Lower half of an operation was produced |
| hiValid | output | 1 | Upper half of an operation was produced |
| flagValid | output | 1 | Flags of an operation were produced |
| flagC | output | 1 | Carry out of bit 31 |
| flagZ | output | 1 | Whole result is zero |
| flagN | output | 1 | Bit 31 of the result |
| flagV | output | 1 | Signed overflow |

## Verification
The hardest case to reach is a dependent chain in which the upper-half bypass must pick up a result that exists for only one cycle: a producer with a carry crossing the half boundary, immediately followed by dependents that use the bypass. The stimulus issues chains of back-to-back operations whose lower halves carry into the upper half, alternating `bypA`, `bypB` and both. It also inserts idle cycles before a bypassed operation to confirm that the held result of the last accepted operation is what gets used.

// File: rtl/stagAddPkg.sv
package stagAddPkg;

  // Strobes from control to datapath; index 0 is operand A, 1 is operand B.
  typedef struct packed {
    logic       ldLo;
    logic       ldHi;
    logic       ldFlag;
    logic [1:0] selLo;
    logic [1:0] selHi;
  } stageCtl_t;

endpackage

// File: rtl/stagAddCtrl.sv
module stagAddCtrl
  import stagAddPkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] bypSel,
  output stageCtl_t  ctl,
  output logic       loValid,
  output logic       hiValid,
  output logic       flagValid
);

  logic       loStageQ;
  logic       hiStageQ;
  logic       flagStageQ;
  logic [1:0] selHiQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loStageQ   <= 1'b0;
      hiStageQ   <= 1'b0;
      flagStageQ <= 1'b0;
      selHiQ     <= 2'b00;
    end else begin
      loStageQ   <= inValid;
      hiStageQ   <= loStageQ;
      flagStageQ <= hiStageQ;
      // The upper half of a bypassed operand is taken one cycle later.
      selHiQ     <= inValid ? bypSel : 2'b00;
    end
  end

  always_comb begin
    ctl.ldLo   = inValid;
    ctl.selLo  = inValid ? bypSel : 2'b00;
    ctl.ldHi   = loStageQ;
    ctl.selHi  = selHiQ;
    ctl.ldFlag = hiStageQ;
  end

  assign loValid   = loStageQ;
  assign hiValid   = hiStageQ;
  assign flagValid = flagStageQ;

endmodule

// File: rtl/stagAddPath.sv
module stagAddPath
  import stagAddPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic [WIDTH-1:0]       opA,
  input  logic [WIDTH-1:0]       opB,
  input  stageCtl_t              ctl,
  output logic [WIDTH/2-1:0]     loSum,
  output logic [WIDTH/2-1:0]     hiSum,
  output logic                   flagC,
  output logic                   flagZ,
  output logic                   flagN,
  output logic                   flagV
);

  localparam int HALF = WIDTH / 2;
  localparam int NOPS = 2;

  logic [HALF-1:0] opLoIn [NOPS];
  logic [HALF-1:0] opHiIn [NOPS];
  logic [HALF-1:0] opHiQ  [NOPS];
  logic [HALF-1:0] loArg  [NOPS];
  logic [HALF-1:0] hiArg  [NOPS];

  logic [HALF-1:0] loRes;
  logic [HALF-1:0] hiRes;
  logic [HALF-1:0] loKeep;
  logic            carryQ;
  logic            cOutQ;
  logic            ovfQ;

  assign opLoIn[0] = opA[HALF-1:0];
  assign opLoIn[1] = opB[HALF-1:0];
  assign opHiIn[0] = opA[WIDTH-1:HALF];
  assign opHiIn[1] = opB[WIDTH-1:HALF];

  for (genvar k = 0; k < NOPS; k++) begin : g_operand
    assign loArg[k] = ctl.selLo[k] ? loRes : opLoIn[k];
    assign hiArg[k] = ctl.selHi[k] ? hiRes : opHiQ[k];

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) opHiQ[k] <= '0;
      else if (ctl.ldLo) opHiQ[k] <= opHiIn[k];
    end
  end

  logic [HALF:0] loFull;
  logic [HALF:0] hiFull;
  logic          ovfNext;

  always_comb begin
    loFull  = {1'b0, loArg[0]} + {1'b0, loArg[1]};
    hiFull  = {1'b0, hiArg[0]} + {1'b0, hiArg[1]} + {{HALF{1'b0}}, carryQ};
    ovfNext = (hiArg[0][HALF-1] == hiArg[1][HALF-1]) &&
              (hiFull[HALF-1] != hiArg[0][HALF-1]);
  end

  // Stage one: lower half and its carry.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      loRes  <= '0;
      carryQ <= 1'b0;
    end else if (ctl.ldLo) begin
      loRes  <= loFull[HALF-1:0];
      carryQ <= loFull[HALF];
    end
  end

  // Stage two: upper half, lower half carried along for the zero test.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hiRes  <= '0;
      loKeep <= '0;
      cOutQ  <= 1'b0;
      ovfQ   <= 1'b0;
    end else if (ctl.ldHi) begin
      hiRes  <= hiFull[HALF-1:0];
      loKeep <= loRes;
      cOutQ  <= hiFull[HALF];
      ovfQ   <= ovfNext;
    end
  end

  // Stage three: flags.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      flagC <= 1'b0;
      flagZ <= 1'b0;
      flagN <= 1'b0;
      flagV <= 1'b0;
    end else if (ctl.ldFlag) begin
      flagC <= cOutQ;
      flagZ <= (hiRes == '0) && (loKeep == '0);
      flagN <= hiRes[HALF-1];
      flagV <= ovfQ;
    end
  end

  assign loSum = loRes;
  assign hiSum = hiRes;

endmodule

// File: rtl/stagAdder.sv
module stagAdder
  import stagAddPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  input  logic [WIDTH-1:0]   opA,
  input  logic [WIDTH-1:0]   opB,
  input  logic               bypA,
  input  logic               bypB,
  output logic [WIDTH/2-1:0] loSum,
  output logic [WIDTH/2-1:0] hiSum,
  output logic               loValid,
  output logic               hiValid,
  output logic               flagValid,
  output logic               flagC,
  output logic               flagZ,
  output logic               flagN,
  output logic               flagV
);

  stageCtl_t ctl;

  stagAddCtrl u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .bypSel   ({bypB, bypA}),
    .ctl      (ctl),
    .loValid  (loValid),
    .hiValid  (hiValid),
    .flagValid(flagValid)
  );

  stagAddPath #(.WIDTH(WIDTH)) u_path (
    .clk  (clk),
    .rstN (rstN),
    .opA  (opA),
    .opB  (opB),
    .ctl  (ctl),
    .loSum(loSum),
    .hiSum(hiSum),
    .flagC(flagC),
    .flagZ(flagZ),
    .flagN(flagN),
    .flagV(flagV)
  );

endmodule

// File: rtl/stagAdderChk.sv
module stagAdderChk #(
  parameter int WIDTH = 32
) (
  input logic               clk,
  input logic               rstN,
  input logic               inValid,
  input logic               loValid,
  input logic               hiValid,
  input logic               flagValid,
  input logic [WIDTH/2-1:0] loSum,
  input logic [WIDTH/2-1:0] hiSum,
  input logic               flagZ,
  input logic               flagN
);

  localparam int HALF = WIDTH / 2;

  // R5
  in_to_lo_chk: assert property (@(posedge clk) disable iff (!rstN)
    inValid |=> loValid);

  // R5
  lo_to_hi_chk: assert property (@(posedge clk) disable iff (!rstN)
    loValid |=> hiValid);

  // R5
  hi_to_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    hiValid |=> flagValid);

  // R9
  lo_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !inValid |=> $stable(loSum));

  // R9
  hi_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !loValid |=> $stable(hiSum));

  // R4
  zero_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> (flagZ == (($past(hiSum) == '0) && ($past(loSum, 2) == '0))));

  // R4
  sign_flag_chk: assert property (@(posedge clk) disable iff (!rstN)
    flagValid |-> (flagN == $past(hiSum[HALF-1])));

endmodule

bind stagAdder stagAdderChk #(.WIDTH(WIDTH)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .inValid  (inValid),
  .loValid  (loValid),
  .hiValid  (hiValid),
  .flagValid(flagValid),
  .loSum    (loSum),
  .hiSum    (hiSum),
  .flagZ    (flagZ),
  .flagN    (flagN)
);

// File: tb/stagAdder_bench.sv
module stagAdder_bench;

  localparam int CLK_PERIOD = 10;
  localparam int MAXOPS = 256;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [31:0] opA = '0;
  logic [31:0] opB = '0;
  logic        bypA = 1'b0;
  logic        bypB = 1'b0;
  logic [15:0] loSum, hiSum;
  logic        loValid, hiValid, flagValid;
  logic        flagC, flagZ, flagN, flagV;

  int total = 0;
  int bad = 0;
  bit running = 1'b0;

  logic [31:0] expSum [MAXOPS];
  logic        expC   [MAXOPS];
  logic        expV   [MAXOPS];
  string       expTag [MAXOPS];
  int          nIssued = 0;
  int          loIdx = 0, hiIdx = 0, flIdx = 0;
  logic [31:0] lastSum = '0;
  logic        iss1 = 1'b0, iss2 = 1'b0, iss3 = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  stagAdder u_stagAdder (
    .clk(clk), .rstN(rstN), .inValid(inValid), .opA(opA), .opB(opB),
    .bypA(bypA), .bypB(bypB), .loSum(loSum), .hiSum(hiSum),
    .loValid(loValid), .hiValid(hiValid), .flagValid(flagValid),
    .flagC(flagC), .flagZ(flagZ), .flagN(flagN), .flagV(flagV)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] got,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  // Bench timing model of the three strobes.
  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      iss1 <= 1'b0; iss2 <= 1'b0; iss3 <= 1'b0;
    end else begin
      iss1 <= inValid; iss2 <= iss1; iss3 <= iss2;
    end
  end

  // Output monitor: outputs settle at the rising edge, sampled at the falling edge.
  always @(negedge clk) begin
    if (rstN && running) begin
      chk(loValid == iss1, "R5 loValid", {31'b0, loValid}, {31'b0, iss1});
      chk(hiValid == iss2, "R5 hiValid", {31'b0, hiValid}, {31'b0, iss2});
      chk(flagValid == iss3, "R5 flagValid", {31'b0, flagValid}, {31'b0, iss3});
      if (loValid) begin
        chk(loSum == expSum[loIdx][15:0], {"R1 loSum ", expTag[loIdx]},
            {16'b0, loSum}, {16'b0, expSum[loIdx][15:0]});
        loIdx++;
      end else if (loIdx > 0) begin
        chk(loSum == expSum[loIdx-1][15:0], "R9 loSum hold",
            {16'b0, loSum}, {16'b0, expSum[loIdx-1][15:0]});
      end
      if (hiValid) begin
        chk(hiSum == expSum[hiIdx][31:16], {"R2 hiSum ", expTag[hiIdx]},
            {16'b0, hiSum}, {16'b0, expSum[hiIdx][31:16]});
        hiIdx++;
      end else if (hiIdx > 0) begin
        chk(hiSum == expSum[hiIdx-1][31:16], "R9 hiSum hold",
            {16'b0, hiSum}, {16'b0, expSum[hiIdx-1][31:16]});
      end
      if (flagValid) begin
        chk(flagC == expC[flIdx], "R3 flagC", {31'b0, flagC}, {31'b0, expC[flIdx]});
        chk(flagV == expV[flIdx], "R3 flagV", {31'b0, flagV}, {31'b0, expV[flIdx]});
        chk(flagZ == (expSum[flIdx] == 32'h0), "R4 flagZ", {31'b0, flagZ},
            {31'b0, (expSum[flIdx] == 32'h0)});
        chk(flagN == expSum[flIdx][31], "R4 flagN", {31'b0, flagN},
            {31'b0, expSum[flIdx][31]});
        flIdx++;
      end
    end
  end

  // Drive one accepted operation for one cycle; starts just after a falling edge.
  task automatic issue(input logic [31:0] a, input logic [31:0] b,
                       input bit ba, input bit bb, input string tag);
    logic [31:0] ea, eb;
    logic [32:0] full;
    ea = ba ? lastSum : a;
    eb = bb ? lastSum : b;
    full = {1'b0, ea} + {1'b0, eb};
    expSum[nIssued] = full[31:0];
    expC[nIssued]   = full[32];
    expV[nIssued]   = (ea[31] == eb[31]) && (full[31] != ea[31]);
    expTag[nIssued] = tag;
    nIssued++;
    lastSum = full[31:0];
    inValid = 1'b1; opA = a; opB = b; bypA = ba; bypB = bb;
    @(negedge clk);
    inValid = 1'b0; bypA = 1'b0; bypB = 1'b0;
  endtask

  task automatic idle(input int n);
    inValid = 1'b0; bypA = 1'b0; bypB = 1'b0;
    // Change operand pins while idle: they must have no effect.
    opA = 32'hDEAD_BEEF; opB = 32'h1234_5678;
    repeat (n) @(negedge clk);
  endtask

  task automatic tReset();
    rstN = 1'b0;
    repeat (3) @(negedge clk);
    chk(!loValid && !hiValid && !flagValid, "R8 valids",
        {29'b0, loValid, hiValid, flagValid}, 32'h0);
    chk(loSum == 16'h0 && hiSum == 16'h0, "R8 sums", {loSum, hiSum}, 32'h0);
    chk({flagC, flagZ, flagN, flagV} == 4'h0, "R8 flags",
        {28'b0, flagC, flagZ, flagN, flagV}, 32'h0);
    rstN = 1'b1;
    @(negedge clk);
    running = 1'b1;
  endtask

  task automatic tBasic();
    issue(32'h0000_0003, 32'h0000_0004, 0, 0, "R1");
    issue(32'h1234_1111, 32'h0101_2222, 0, 0, "R1");
    issue(32'h0000_FFFF, 32'h0000_0001, 0, 0, "R2");
    issue(32'h00FF_8000, 32'h0001_8000, 0, 0, "R2");
    idle(4);
  endtask

  task automatic tFlags();
    issue(32'h7FFF_FFFF, 32'h0000_0001, 0, 0, "R3");
    issue(32'hFFFF_FFFF, 32'h0000_0001, 0, 0, "R4");
    issue(32'h8000_0000, 32'h8000_0000, 0, 0, "R3");
    issue(32'h0001_0000, 32'hFFFF_0000, 0, 0, "R4");
    issue(32'h0000_0000, 32'h0000_0000, 0, 0, "R4");
    issue(32'hF000_0000, 32'h0000_1234, 0, 0, "R4");
    idle(4);
  endtask

  task automatic tChainA();
    issue(32'h0000_FFF0, 32'h0000_0020, 0, 0, "R6");
    issue(32'h0,         32'h0000_FFFF, 1, 0, "R6");
    issue(32'h0,         32'h7FFF_8000, 1, 0, "R6");
    issue(32'h0,         32'h0000_0001, 1, 0, "R6");
    idle(4);
  endtask

  task automatic tChainB();
    issue(32'h4000_C000, 32'h0000_4000, 0, 0, "R7");
    issue(32'h0001_8000, 32'h0,         0, 1, "R7");
    issue(32'h0,         32'h0,         1, 1, "R7");
    issue(32'h0,         32'h0,         1, 1, "R7");
    issue(32'hFFFF_FFFF, 32'h0,         0, 1, "R7");
    idle(4);
  endtask

  task automatic tGapBypass();
    issue(32'h1234_F00F, 32'h0000_1FF1, 0, 0, "R6");
    idle(1);
    issue(32'h0,         32'h0000_0100, 1, 0, "R6");
    idle(3);
    issue(32'h0,         32'hABCD_0001, 0, 1, "R7");
    idle(5);
  endtask

  task automatic tStream();
    for (int i = 0; i < 20; i++)
      issue(32'h0F0F_F0F0 * (i + 1), 32'h3333_9999 ^ i, (i % 3) == 1, (i % 4) == 2, "R5");
    idle(5);
  endtask

  initial begin
    tReset();
    tBasic();
    tFlags();
    tChainA();
    tChainB();
    tGapBypass();
    tStream();
    chk(flIdx == nIssued, "R5 op count", flIdx, nIssued);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    bad++;
    $display("FAIL watchdog expired got=%0d exp=%0d", flIdx, nIssued);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule